// File: doc/BRIEF.md
# Dynamic Address Assignment Tracker

This block watches a decoded two-wire bus event stream (start, repeated start, stop, received bytes, acknowledge bits and transition bits) and follows the address-assignment procedure that a controller runs after broadcasting the enter-assignment command. For every target that joins a round, it gathers the eight identity bytes (a 48-bit provisioned ID, a bus characteristics byte and a device characteristics byte), then the byte that carries the assigned address. It reports them as one record with a one-cycle valid strobe and a flag that tells whether the address byte has odd parity.

Every address learned this way is written into a 128-entry known-address bitmap. Addresses that follow a repeated start in a frame that earlier carried the broadcast header are also written into the bitmap, outside assignment mode. The bitmap has a synchronous clear. The write port that feeds it is visible at the block's outputs, so a neighbour can keep its own copy.

Events arrive one per cycle with `ev_valid`. The event kinds are coded on `ev_kind` as 0 start, 1 repeated start, 2 stop, 3 byte, 4 acknowledge bit, 5 transition bit. `ev_data` carries the byte, or the bit value in bit 0.

Top module: `daa_tracker`

## Requirements
- R1: After reset, `rec_valid`, `tbl_wr_en` and every bit of `known_map` are 0.
- R2: Assignment mode is entered only by this sequence: a start, the header byte 0xFC (broadcast address 0x7E with the write bit), acknowledge value 0, the command byte 0x07, then a transition-bit event. Any other command byte leaves the mode off.
- R3: In assignment mode, a repeated start, header byte 0xFD and acknowledge value 0 open a round. The next eight bytes are the identity: bytes 0 to 5 form `rec_pid` with byte 0 in bits 47:40, byte 6 is `rec_bcr` and byte 7 is `rec_dcr`. The ninth byte gives `rec_addr` from its bits 7:1. `rec_valid` is high for exactly the cycle after that ninth byte event, and the record fields hold their values until the next record.
- R4: `rec_parity_ok` is 1 when the ninth byte contains an odd number of ones, and 0 otherwise.
- R5: An acknowledge value 1 on a round header ends assignment mode, so later rounds produce no record until the mode is entered again.
- R6: Each record writes its address. `tbl_wr_en` is high with `tbl_wr_addr` equal to the address in the same cycle as `rec_valid`, and the matching bit of `known_map` is 1 from the following cycle.
- R7: A stop ends assignment mode and discards any partially gathered identity. A new round restarts the byte count from zero.
- R8: Outside assignment mode, after a frame has carried the broadcast header, the 7-bit address of a header byte that follows a repeated start is written to the bitmap one cycle after the byte. A header byte after a plain start, or in a frame without the broadcast header, writes nothing.
- R9: `tbl_clear` zeroes `known_map` at the next clock edge. A clear takes priority over a write that lands on the same edge.
- R10: Cycles with `ev_valid` low change no state and produce no output, whatever `ev_kind` and `ev_data` hold.
- R11: After the acknowledge bit of an address byte, a further repeated start with header 0xFD opens the next round in the same assignment session.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_valid | input | 1 | Event present this cycle |
| ev_kind | input | 3 | Event kind: 0 start, 1 repeated start, 2 stop, 3 byte, 4 acknowledge bit, 5 transition bit |
| ev_data | input | 8 | Byte value, or bit value in bit 0 |
| tbl_clear | input | 1 | Synchronous clear of the known-address bitmap |
| rec_valid | output | 1 | One-cycle strobe for a completed record |
| rec_pid | output | 48 | Provisioned ID of the last record |
| rec_bcr | output | 8 | Bus characteristics byte of the last record |
| rec_dcr | output | 8 | Device characteristics byte of the last record |
| rec_addr | output | 7 | Assigned address of the last record |
| rec_parity_ok | output | 1 | Address byte of the last record had odd parity |
| tbl_wr_en | output | 1 | Bitmap write strobe |
| tbl_wr_addr | output | 7 | Bitmap write address |
| known_map | output | 128 | Known-address bitmap, bit n for address n |

## Verification
The assertions assume that the event stream is well formed: at most one event per cycle, acknowledge and transition bits only where the bus protocol puts them, and a stop or start between frames. They also assume that `tbl_clear` is a plain level sampled at the clock edge. The stimulus is built only from whole-frame tasks (start, header, acknowledge, bytes, stop), so every event sequence is one a frame monitor could produce. The only irregularities added on purpose are idle cycles with garbage on `ev_kind`/`ev_data` and `ev_valid` low, an early stop in the middle of an identity burst, and clears that collide with pending writes.

// File: rtl/daa_trk_pkg.sv
// Shared encodings for the dynamic address assignment tracker.
// Assumes the event producer uses the kind codes listed below.
package daa_trk_pkg;

    typedef enum logic [2:0] {
        EV_START   = 3'd0,
        EV_RSTART  = 3'd1,
        EV_STOP    = 3'd2,
        EV_BYTE    = 3'd3,
        EV_ACKBIT  = 3'd4,
        EV_TBIT    = 3'd5
    } ev_kind_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HDR,
        ST_BC_ACK,
        ST_CCC,
        ST_CCC_T,
        ST_RND_ACK,
        ST_ID,
        ST_ADDR,
        ST_ADDR_ACK
    } trk_state_e;

    localparam logic [6:0] BCAST_ADDR    = 7'h7E;
    localparam logic [7:0] CCC_ENTER_DAA = 8'h07;

endpackage

// File: rtl/daa_trk_seq.sv
// Protocol sequencer: follows frame headers, broadcast command detection and
// assignment rounds. It emits one-cycle strobes for an identity byte, an
// address byte and an address to learn outside assignment mode.
// Assumes at most one event per cycle, qualified by ev_valid.
module daa_trk_seq
    import daa_trk_pkg::*;
#(
    parameter int ID_BYTES = 8,
    parameter int ADDR_W   = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ev_valid,
    input  logic [2:0]    ev_kind,
    input  logic [ADDR_W:0] ev_data,
    output logic          id_shift,
    output logic          rec_emit,
    output logic          learn_req
);
    localparam int CNT_W = (ID_BYTES > 1) ? $clog2(ID_BYTES) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ID_BYTES - 1);

    trk_state_e       state_q;
    logic             daa_q;
    logic             bcast_q;
    logic             rep_q;
    logic [CNT_W-1:0] cnt_q;

    ev_kind_e kind;
    logic     is_byte;
    logic     hdr_bcast;
    logic     hdr_round;

    // Decode the current event and header byte.
    always_comb begin
        kind      = ev_kind_e'(ev_kind);
        is_byte   = ev_valid && (kind == EV_BYTE);
        hdr_bcast = (ev_data[ADDR_W:1] == BCAST_ADDR);
        hdr_round = daa_q && rep_q && hdr_bcast && ev_data[0];
    end

    // Strobes towards the capture register and the address table.
    always_comb begin
        id_shift  = is_byte && (state_q == ST_ID);
        rec_emit  = is_byte && (state_q == ST_ADDR);
        learn_req = is_byte && (state_q == ST_HDR) && rep_q && bcast_q
                    && !daa_q && !hdr_bcast;
    end

    // Frame and assignment-round state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            daa_q   <= 1'b0;
            bcast_q <= 1'b0;
            rep_q   <= 1'b0;
            cnt_q   <= '0;
        end else if (ev_valid) begin
            case (kind)
                EV_START: begin
                    state_q <= ST_HDR;
                    rep_q   <= 1'b0;
                    bcast_q <= 1'b0;
                end
                EV_RSTART: begin
                    state_q <= ST_HDR;
                    rep_q   <= 1'b1;
                end
                EV_STOP: begin
                    state_q <= ST_IDLE;
                    daa_q   <= 1'b0;
                    bcast_q <= 1'b0;
                    cnt_q   <= '0;
                end
                EV_BYTE: begin
                    case (state_q)
                        ST_HDR: begin
                            if (hdr_round) begin
                                state_q <= ST_RND_ACK;
                            end else if (hdr_bcast) begin
                                if (!daa_q) bcast_q <= 1'b1;
                                state_q <= ev_data[0] ? ST_IDLE : ST_BC_ACK;
                            end else begin
                                state_q <= ST_IDLE;
                            end
                        end
                        ST_CCC:
                            state_q <= (ev_data == CCC_ENTER_DAA) ? ST_CCC_T : ST_IDLE;
                        ST_ID: begin
                            if (cnt_q == LAST_IDX) state_q <= ST_ADDR;
                            cnt_q <= cnt_q + CNT_W'(1);
                        end
                        ST_ADDR:
                            state_q <= ST_ADDR_ACK;
                        default: ;
                    endcase
                end
                EV_ACKBIT: begin
                    case (state_q)
                        ST_BC_ACK:
                            state_q <= ev_data[0] ? ST_IDLE : ST_CCC;
                        ST_RND_ACK: begin
                            cnt_q <= '0;
                            if (ev_data[0]) begin
                                daa_q   <= 1'b0;
                                state_q <= ST_IDLE;
                            end else begin
                                state_q <= ST_ID;
                            end
                        end
                        ST_ADDR_ACK:
                            state_q <= ST_IDLE;
                        default: ;
                    endcase
                end
                EV_TBIT: begin
                    if (state_q == ST_CCC_T) begin
                        daa_q   <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/daa_trk_capture.sv
// Identity capture: shifts identity bytes in, most significant first, and
// publishes a record with the address byte and its parity verdict.
// Assumes the sequencer raises id_shift exactly ID_BYTES times per round.
module daa_trk_capture #(
    parameter int ID_BYTES = 8,
    parameter int ADDR_W   = 7
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         id_shift,
    input  logic                         rec_emit,
    input  logic [ADDR_W:0]              byte_in,
    output logic                         rec_valid,
    output logic [ID_BYTES*(ADDR_W+1)-1:0] rec_id,
    output logic [ADDR_W-1:0]            rec_addr,
    output logic                         rec_parity_ok
);
    localparam int BYTE_W = ADDR_W + 1;
    localparam int ID_W   = ID_BYTES * BYTE_W;

    logic [ID_W-1:0] id_sr;

    // Identity shift register, earliest byte ends up most significant.
    always_ff @(posedge clk) begin
        if (!rst_n)        id_sr <= '0;
        else if (id_shift) id_sr <= {id_sr[ID_W-BYTE_W-1:0], byte_in};
    end

    // Record publication on the address byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_valid     <= 1'b0;
            rec_id        <= '0;
            rec_addr      <= '0;
            rec_parity_ok <= 1'b0;
        end else begin
            rec_valid <= rec_emit;
            if (rec_emit) begin
                rec_id        <= id_sr;
                rec_addr      <= byte_in[ADDR_W:1];
                rec_parity_ok <= ^byte_in;
            end
        end
    end

endmodule

// File: rtl/daa_trk_table.sv
// Known-address bitmap: registers one write request per cycle and sets the
// addressed bit on the following edge; a synchronous clear wins over a write.
// Assumes requests are single-cycle strobes.
module daa_trk_table #(
    parameter int ADDR_W = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 req_en,
    input  logic [ADDR_W-1:0]    req_addr,
    output logic                 wr_en,
    output logic [ADDR_W-1:0]    wr_addr,
    output logic [2**ADDR_W-1:0] known_map
);
    localparam int DEPTH = 2 ** ADDR_W;

    // Write port register, visible to neighbours.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_addr <= '0;
        end else begin
            wr_en <= req_en;
            if (req_en) wr_addr <= req_addr;
        end
    end

    // One sticky flag per address.
    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n || clear)
                known_map[i] <= 1'b0;
            else if (wr_en && (wr_addr == ADDR_W'(i)))
                known_map[i] <= 1'b1;
        end
    end

endmodule

// File: rtl/daa_tracker.sv
// Top of the dynamic address assignment tracker. Joins the sequencer, the
// identity capture and the known-address bitmap, and splits the identity into
// ID, bus characteristics and device characteristics fields.
// Assumes a well-formed event stream from a frame monitor.
module daa_tracker #(
    parameter int ID_BYTES = 8,
    parameter int ADDR_W   = 7
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            ev_valid,
    input  logic [2:0]                      ev_kind,
    input  logic [ADDR_W:0]                 ev_data,
    input  logic                            tbl_clear,
    output logic                            rec_valid,
    output logic [(ID_BYTES-2)*(ADDR_W+1)-1:0] rec_pid,
    output logic [ADDR_W:0]                 rec_bcr,
    output logic [ADDR_W:0]                 rec_dcr,
    output logic [ADDR_W-1:0]               rec_addr,
    output logic                            rec_parity_ok,
    output logic                            tbl_wr_en,
    output logic [ADDR_W-1:0]               tbl_wr_addr,
    output logic [2**ADDR_W-1:0]            known_map
);
    localparam int BYTE_W = ADDR_W + 1;
    localparam int ID_W   = ID_BYTES * BYTE_W;
    localparam int PID_W  = ID_W - 2 * BYTE_W;

    logic            id_shift;
    logic            rec_emit;
    logic            learn_req;
    logic [ID_W-1:0] rec_id;

    daa_trk_seq #(.ID_BYTES(ID_BYTES), .ADDR_W(ADDR_W)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_valid  (ev_valid),
        .ev_kind   (ev_kind),
        .ev_data   (ev_data),
        .id_shift  (id_shift),
        .rec_emit  (rec_emit),
        .learn_req (learn_req)
    );

    daa_trk_capture #(.ID_BYTES(ID_BYTES), .ADDR_W(ADDR_W)) cap_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .id_shift      (id_shift),
        .rec_emit      (rec_emit),
        .byte_in       (ev_data),
        .rec_valid     (rec_valid),
        .rec_id        (rec_id),
        .rec_addr      (rec_addr),
        .rec_parity_ok (rec_parity_ok)
    );

    daa_trk_table #(.ADDR_W(ADDR_W)) tbl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (tbl_clear),
        .req_en    (rec_emit || learn_req),
        .req_addr  (ev_data[ADDR_W:1]),
        .wr_en     (tbl_wr_en),
        .wr_addr   (tbl_wr_addr),
        .known_map (known_map)
    );

    // Field split of the captured identity.
    always_comb begin
        rec_pid = rec_id[ID_W-1 -: PID_W];
        rec_bcr = rec_id[2*BYTE_W-1 -: BYTE_W];
        rec_dcr = rec_id[BYTE_W-1:0];
    end

endmodule

// File: rtl/daa_tracker_chk.sv
// Property checker for the tracker, bound to every instance of the top.
// Assumes synchronous active-low reset held for at least one edge.
module daa_tracker_chk #(
    parameter int ADDR_W = 7,
    parameter int PID_W  = 48
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ev_valid,
    input logic [2:0]           ev_kind,
    input logic                 tbl_clear,
    input logic                 rec_valid,
    input logic [PID_W-1:0]     rec_pid,
    input logic [ADDR_W-1:0]    rec_addr,
    input logic                 tbl_wr_en,
    input logic [ADDR_W-1:0]    tbl_wr_addr,
    input logic [2**ADDR_W-1:0] known_map
);
    // R6: a record always comes with a bitmap write of its own address
    p_rec_writes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> (tbl_wr_en && tbl_wr_addr == rec_addr));

    // R6 / R8: an uncleared write is visible in the bitmap next cycle
    p_write_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_wr_en && !tbl_clear) |=> known_map[$past(tbl_wr_addr)]);

    // R9: clear empties the bitmap, even against a pending write
    p_clear_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_clear |=> (known_map == '0));

    // R7: a stop event never produces a record
    p_stop_no_rec_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_kind == 3'd2) |=> !rec_valid);

    // R3: record fields hold between strobes
    p_rec_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rec_valid |-> ($stable(rec_pid) && $stable(rec_addr)));

    // R10: an idle cycle creates no record on the next edge
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_valid |=> !rec_valid);

endmodule

bind daa_tracker daa_tracker_chk #(.ADDR_W(ADDR_W), .PID_W(PID_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_valid    (ev_valid),
    .ev_kind     (ev_kind),
    .tbl_clear   (tbl_clear),
    .rec_valid   (rec_valid),
    .rec_pid     (rec_pid),
    .rec_addr    (rec_addr),
    .tbl_wr_en   (tbl_wr_en),
    .tbl_wr_addr (tbl_wr_addr),
    .known_map   (known_map)
);

// File: tb/daa_tracker_tb_top.sv
// Bench: behavioural reference model compared on every clock, plus named
// checks for each requirement.
module daa_tracker_tb_top;

    localparam int K_START = 0, K_RSTART = 1, K_STOP = 2, K_BYTE = 3, K_ACK = 4, K_TBIT = 5;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         ev_valid;
    logic [2:0]   ev_kind;
    logic [7:0]   ev_data;
    logic         tbl_clear;
    logic         rec_valid;
    logic [47:0]  rec_pid;
    logic [7:0]   rec_bcr;
    logic [7:0]   rec_dcr;
    logic [6:0]   rec_addr;
    logic         rec_parity_ok;
    logic         tbl_wr_en;
    logic [6:0]   tbl_wr_addr;
    logic [127:0] known_map;

    int checks = 0;
    int fails  = 0;
    int rec_seen = 0;
    logic [47:0] last_pid;
    logic [7:0]  last_bcr, last_dcr;
    logic [6:0]  last_addr;
    logic        last_par;

    // reference model state
    bit   m_daa, m_bc, m_rep;
    int   m_ph;
    logic [7:0] id_q[$];
    logic         exp_rv, exp_par, exp_wr;
    logic [47:0]  exp_pid;
    logic [7:0]   exp_bcr, exp_dcr;
    logic [6:0]   exp_addr, exp_wa;
    logic [127:0] exp_map;

    always #2.5 clk = ~clk;

    daa_tracker dut_i (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
        .ev_data(ev_data), .tbl_clear(tbl_clear), .rec_valid(rec_valid),
        .rec_pid(rec_pid), .rec_bcr(rec_bcr), .rec_dcr(rec_dcr),
        .rec_addr(rec_addr), .rec_parity_ok(rec_parity_ok),
        .tbl_wr_en(tbl_wr_en), .tbl_wr_addr(tbl_wr_addr), .known_map(known_map)
    );

    task automatic check(input bit ok, input string req,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_daa = 0; m_bc = 0; m_rep = 0; m_ph = 0; id_q.delete();
        exp_rv = 0; exp_par = 0; exp_wr = 0; exp_pid = '0; exp_bcr = '0;
        exp_dcr = '0; exp_addr = '0; exp_wa = '0; exp_map = '0;
    endtask

    // expected outputs after the coming edge
    task automatic model(input bit v, input int k, input logic [7:0] d, input bit clr);
        if (clr) exp_map = '0;
        else if (exp_wr) exp_map[exp_wa] = 1'b1;
        exp_rv = 0;
        exp_wr = 0;
        if (v) begin
            case (k)
                K_START:  begin m_ph = 1; m_rep = 0; m_bc = 0; end
                K_RSTART: begin m_ph = 1; m_rep = 1; end
                K_STOP:   begin m_ph = 0; m_daa = 0; m_bc = 0; id_q.delete(); end
                K_BYTE: begin
                    if (m_ph == 1) begin
                        if (m_daa && m_rep && d == 8'hFD) m_ph = 5;
                        else if (d[7:1] == 7'h7E) begin
                            if (!m_daa) m_bc = 1;
                            m_ph = d[0] ? 0 : 2;
                        end else begin
                            if (m_rep && m_bc && !m_daa) begin exp_wr = 1; exp_wa = d[7:1]; end
                            m_ph = 0;
                        end
                    end else if (m_ph == 3) begin
                        m_ph = (d == 8'h07) ? 4 : 0;
                    end else if (m_ph == 6) begin
                        id_q.push_back(d);
                        if (id_q.size() == 8) m_ph = 7;
                    end else if (m_ph == 7) begin
                        exp_rv = 1;
                        exp_pid = {id_q[0], id_q[1], id_q[2], id_q[3], id_q[4], id_q[5]};
                        exp_bcr = id_q[6];
                        exp_dcr = id_q[7];
                        exp_addr = d[7:1];
                        exp_par = ^d;
                        exp_wr = 1; exp_wa = d[7:1];
                        m_ph = 8;
                    end
                end
                K_ACK: begin
                    if (m_ph == 2) m_ph = d[0] ? 0 : 3;
                    else if (m_ph == 5) begin
                        id_q.delete();
                        if (d[0]) begin m_daa = 0; m_ph = 0; end
                        else m_ph = 6;
                    end else if (m_ph == 8) m_ph = 0;
                end
                K_TBIT: if (m_ph == 4) begin m_daa = 1; m_ph = 0; end
                default: ;
            endcase
        end
    endtask

    task automatic compare();
        check(rec_valid === exp_rv, "R3 strobe", rec_valid, exp_rv);
        check(rec_pid === exp_pid && rec_bcr === exp_bcr && rec_dcr === exp_dcr
              && rec_addr === exp_addr, "R3 fields",
              {rec_pid, rec_bcr, rec_dcr, rec_addr}, {exp_pid, exp_bcr, exp_dcr, exp_addr});
        check(rec_parity_ok === exp_par, "R4", rec_parity_ok, exp_par);
        check(tbl_wr_en === exp_wr, "R6 write strobe", tbl_wr_en, exp_wr);
        if (exp_wr) check(tbl_wr_addr === exp_wa, "R6 write addr", tbl_wr_addr, exp_wa);
        check(known_map === exp_map, "R6 bitmap", known_map, exp_map);
        if (rec_valid === 1'b1) begin
            rec_seen++;
            last_pid = rec_pid; last_bcr = rec_bcr; last_dcr = rec_dcr;
            last_addr = rec_addr; last_par = rec_parity_ok;
        end
    endtask

    task automatic cyc(input bit v, input int k, input logic [7:0] d, input bit clr);
        ev_valid = v; ev_kind = 3'(k); ev_data = d; tbl_clear = clr;
        model(v, k, d, clr);
        @(posedge clk);
        @(negedge clk);
        compare();
        ev_valid = 0; tbl_clear = 0;
    endtask

    task automatic ev(input int k, input logic [7:0] d);
        cyc(1'b1, k, d, 1'b0);
    endtask

    task automatic enter_mode(input logic [7:0] code);
        ev(K_START, 0); ev(K_BYTE, 8'hFC); ev(K_ACK, 0); ev(K_BYTE, code); ev(K_TBIT, 0);
    endtask

    task automatic round(input logic [63:0] id, input logic [7:0] ab, input bit gap);
        ev(K_RSTART, 0); ev(K_BYTE, 8'hFD); ev(K_ACK, 0);
        for (int i = 7; i >= 0; i--) begin
            ev(K_BYTE, id[i*8 +: 8]);
            if (gap && i == 4) cyc(1'b0, K_BYTE, 8'hFF, 1'b0);
        end
        ev(K_BYTE, ab); ev(K_ACK, 0);
    endtask

    initial begin
        int n;
        ev_valid = 0; ev_kind = 0; ev_data = 0; tbl_clear = 0; rst_n = 0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        check(rec_valid === 0 && tbl_wr_en === 0, "R1 strobes", {rec_valid, tbl_wr_en}, 0);
        check(known_map === '0, "R1 bitmap", known_map, 0);

        // R2 / R3 / R4 / R6: first round with good parity
        enter_mode(8'h07);
        n = rec_seen;
        round(64'h0123456789AB_C3_5A, 8'h15, 0);
        check(rec_seen == n + 1, "R3 one record", rec_seen, n + 1);
        check(last_pid === 48'h0123456789AB, "R3 pid", last_pid, 48'h0123456789AB);
        check(last_bcr === 8'hC3 && last_dcr === 8'h5A, "R3 bcr/dcr", {last_bcr, last_dcr}, 16'hC35A);
        check(last_addr === 7'h0A, "R3 addr", last_addr, 7'h0A);
        check(last_par === 1'b1, "R4 odd parity", last_par, 1);
        check(known_map[7'h0A] === 1'b1, "R6 bit set", known_map[7'h0A], 1);

        // R11 / R4 / R10: second round, bad parity, idle garbage cycle inside
        round(64'hFEDCBA987654_11_22, 8'h41, 1);
        check(rec_seen == n + 2, "R11 second record", rec_seen, n + 2);
        check(last_par === 1'b0, "R4 even parity", last_par, 0);
        check(last_pid === 48'hFEDCBA987654, "R10 idle ignored", last_pid, 48'hFEDCBA987654);

        // R5: NACK on round header ends the mode
        ev(K_RSTART, 0); ev(K_BYTE, 8'hFD); ev(K_ACK, 1);
        n = rec_seen;
        round(64'h1111_2222_3333_4444, 8'h23, 0);
        check(rec_seen == n, "R5 no record after NACK", rec_seen, n);
        ev(K_STOP, 0);

        // R2: other command code does not enter the mode
        enter_mode(8'h06);
        round(64'h5555_6666_7777_8888, 8'h25, 0);
        check(rec_seen == n, "R2 wrong code", rec_seen, n);
        ev(K_STOP, 0);

        // R7: stop mid-burst ends mode; next round restarts count
        enter_mode(8'h07);
        ev(K_RSTART, 0); ev(K_BYTE, 8'hFD); ev(K_ACK, 0);
        ev(K_BYTE, 8'hAA); ev(K_BYTE, 8'hBB); ev(K_BYTE, 8'hCC);
        ev(K_STOP, 0);
        ev(K_START, 0); ev(K_BYTE, 8'hFD); ev(K_ACK, 0);
        for (int i = 0; i < 9; i++) ev(K_BYTE, 8'(8'h30 + i));
        check(rec_seen == n, "R7 stop ends mode", rec_seen, n);
        ev(K_STOP, 0);
        enter_mode(8'h07);
        ev(K_RSTART, 0); ev(K_BYTE, 8'hFD); ev(K_ACK, 0);
        ev(K_BYTE, 8'hAA); ev(K_BYTE, 8'hBB); ev(K_BYTE, 8'hCC);
        round(64'h0A0B0C0D0E0F_1020, 8'h61, 0);
        check(last_pid === 48'h0A0B0C0D0E0F, "R7 count restarts", last_pid, 48'h0A0B0C0D0E0F);
        ev(K_STOP, 0);

        // R8: learning after broadcast header
        ev(K_START, 0); ev(K_BYTE, 8'hFC); ev(K_ACK, 0); ev(K_BYTE, 8'h01); ev(K_TBIT, 0);
        ev(K_RSTART, 0); ev(K_BYTE, 8'hA4);
        check(tbl_wr_en === 1 && tbl_wr_addr === 7'h52, "R8 learn write",
              {tbl_wr_en, tbl_wr_addr}, {1'b1, 7'h52});
        ev(K_STOP, 0);
        ev(K_START, 0); ev(K_BYTE, 8'hA6); ev(K_RSTART, 0); ev(K_BYTE, 8'hA6);
        ev(K_STOP, 0);
        check(known_map[7'h53] === 1'b0, "R8 no broadcast no learn", known_map[7'h53], 0);
        check(known_map[7'h52] === 1'b1, "R8 learned bit", known_map[7'h52], 1);

        // R9: clear, then clear colliding with pending write
        cyc(1'b0, K_BYTE, 8'h00, 1'b1);
        check(known_map === '0, "R9 clear", known_map, 0);
        ev(K_START, 0); ev(K_BYTE, 8'hFC); ev(K_ACK, 0); ev(K_BYTE, 8'h01); ev(K_TBIT, 0);
        ev(K_RSTART, 0); ev(K_BYTE, 8'h10);
        cyc(1'b0, K_BYTE, 8'h00, 1'b1);
        check(known_map === '0, "R9 clear wins", known_map, 0);
        cyc(1'b0, K_STOP, 8'h00, 1'b0);
        check(known_map === '0, "R9 stays clear", known_map, 0);
        ev(K_STOP, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule